// File: doc/BRIEF.md
# Interpolating Quadrature Encoder Output Generator

This block turns a stream of absolute angle samples, each a position inside one signal period of 960 counts, into a pair of incremental square waves in quadrature. One period at the input yields between one and sixteen full output cycles. The number is picked by two three-level resolution pins. Every output cycle holds four segments of equal width. A position follower with a per-resolution dead band sits in front of the segment counter. Motion in the current direction passes through at once. After a reversal, the input must first travel back through the whole dead band before the outputs move, so a still or jittering input never toggles them.

A third three-level pin sets which output leads for a given direction. Its middle level also turns on a sync output. That output is the most significant half of the angle, high for the upper half of each period. The segment counter moves at most one segment per clock. A large jump in angle therefore appears as a burst of clean quadrature edges, one clock apart, along the shorter way around the circle.

Samples arrive on a valid/ready stream. The block never stalls once it is out of reset. A sample is taken in every cycle where both valid and ready are high. Without valid, the input bus is not looked at. Ready is low while reset is held. Resolution and phase pins are treated as static configuration and are set while reset is held. A pin encoding is 00 for low, 01 for open and 10 for high, and 11 is read as open.

Top module: `interp_quad_gen`

## Requirements
- R1: The resolution pins (`res_coarse`, `res_fine`; 00 low, 01 open, 10 high, 11 read as open) select the interpolation factor: high/high 16, high/open 12, high/low 10, open/high 8, open/open 5, open/low 4, low/high 3, low/open 2, low/low 1.
- R2: For rising angle, a segment boundary lies at every multiple of 960/(4*factor) counts. The output segment is the follower position divided by that width, rounded down.
- R3: With `phase_sel` low or open, the segment number modulo 4 maps to (A,B) as 0→(0,0), 1→(0,1), 2→(1,1), 3→(1,0). Rising angle therefore makes B lead A.
- R4: With `phase_sel` high, A and B trade places in the R3 map: 1→(1,0), 3→(0,1). Rising angle then makes A lead B.
- R5: After a reversal, the follower position holds until the angle has moved more than the dead band past it. It then trails the angle by exactly the dead band. The dead band is 15 counts for factors 1, 2, 4, 8 and 16, 20 counts for factors 3 and 12, and 24 counts for factors 5 and 10.
- R6: A constant input, or cycles without an accepted sample, leave A and B unchanged.
- R7: At most one of A and B changes per clock. A jump of several segments is walked one segment per clock, wrapping around, in the direction of the shorter arc.
- R8: With `phase_sel` open (01 or 11), `sync_out` is high when the last accepted angle is 480 or more. It updates on the clock that accepts the sample. With `phase_sel` high or low, `sync_out` is low.
- R9: Reset is synchronous and active high. It clears the follower position and the segment to 0, so A, B and `sync_out` are low after reset.
- R10: `in_ready` is low during reset and high otherwise. A sample is taken only when `in_valid` and `in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Angle sample present |
| in_ready | output | 1 | Block accepts samples (low in reset) |
| in_angle | input | 10 | Angle within one period, 0 to 959 |
| res_coarse | input | 2 | First resolution pin, three-level |
| res_fine | input | 2 | Second resolution pin, three-level |
| phase_sel | input | 2 | Phase relation / sync enable, three-level |
| quad_a | output | 1 | Quadrature output A |
| quad_b | output | 1 | Quadrature output B |
| sync_out | output | 1 | Upper-half-period flag when phase_sel is open, else low |

## Verification
Several rules are checked every cycle by assertions. A and B never switch together while the configuration is steady. The segment counter only ever steps by one, with wrap. The segment stays inside the range of the selected factor. The follower position does not move in a cycle without an accepted sample. Both outputs read low after reset. The rest can only be shown by directed scenarios with known angles: the segment widths of all nine factors, which output leads for each phase setting, the exact angle where a reversed direction first shows up for each dead-band group, the edge count and shortest-arc direction of large jumps, and the sync level at the half-period boundary.

// File: rtl/quadgen_pkg.sv
package quadgen_pkg;

  typedef enum logic [1:0] {
    LVL_LO   = 2'b00,
    LVL_OPEN = 2'b01,
    LVL_HI   = 2'b10
  } tri_lvl_e;

  // A three-level pin reads 11 as open.
  function automatic tri_lvl_e lvl_norm(input logic [1:0] raw);
    if (raw == 2'b11) return LVL_OPEN;
    return tri_lvl_e'(raw);
  endfunction

endpackage

// File: rtl/quadgen_res_decode.sv
module quadgen_res_decode
  import quadgen_pkg::*;
#(
  parameter int CYC = 960,
  parameter int PW  = 10,
  parameter int SW  = 7
) (
  input  logic [1:0]    sel_coarse,
  input  logic [1:0]    sel_fine,
  output logic [PW-1:0] span,
  output logic [PW-1:0] hyst,
  output logic [SW-1:0] nseg
);
  // Segment width per factor: one period split into 4*factor parts.
  localparam logic [PW-1:0] SP16 = PW'(CYC / 64);
  localparam logic [PW-1:0] SP12 = PW'(CYC / 48);
  localparam logic [PW-1:0] SP10 = PW'(CYC / 40);
  localparam logic [PW-1:0] SP8  = PW'(CYC / 32);
  localparam logic [PW-1:0] SP5  = PW'(CYC / 20);
  localparam logic [PW-1:0] SP4  = PW'(CYC / 16);
  localparam logic [PW-1:0] SP3  = PW'(CYC / 12);
  localparam logic [PW-1:0] SP2  = PW'(CYC / 8);
  localparam logic [PW-1:0] SP1  = PW'(CYC / 4);
  // Dead bands: 1/64, 1/48 and 1/40 of a period.
  localparam logic [PW-1:0] HB_A = PW'(CYC / 64);
  localparam logic [PW-1:0] HB_B = PW'(CYC / 48);
  localparam logic [PW-1:0] HB_C = PW'(CYC / 40);

  tri_lvl_e lv_c, lv_f;

  always_comb begin
    lv_c = lvl_norm(sel_coarse);
    lv_f = lvl_norm(sel_fine);
    span = SP1;
    hyst = HB_A;
    nseg = SW'(4);
    case ({lv_c, lv_f})
      {LVL_HI,   LVL_HI  }: begin span = SP16; hyst = HB_A; nseg = SW'(64); end
      {LVL_HI,   LVL_OPEN}: begin span = SP12; hyst = HB_B; nseg = SW'(48); end
      {LVL_HI,   LVL_LO  }: begin span = SP10; hyst = HB_C; nseg = SW'(40); end
      {LVL_OPEN, LVL_HI  }: begin span = SP8;  hyst = HB_A; nseg = SW'(32); end
      {LVL_OPEN, LVL_OPEN}: begin span = SP5;  hyst = HB_C; nseg = SW'(20); end
      {LVL_OPEN, LVL_LO  }: begin span = SP4;  hyst = HB_A; nseg = SW'(16); end
      {LVL_LO,   LVL_HI  }: begin span = SP3;  hyst = HB_B; nseg = SW'(12); end
      {LVL_LO,   LVL_OPEN}: begin span = SP2;  hyst = HB_A; nseg = SW'(8);  end
      default:              begin span = SP1;  hyst = HB_A; nseg = SW'(4);  end
    endcase
  end
endmodule

// File: rtl/quadgen_hyst_track.sv
module quadgen_hyst_track #(
  parameter int CYC = 960,
  parameter int PW  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_take,
  input  logic [PW-1:0] smp_angle,
  input  logic [PW-1:0] hyst,
  output logic [PW-1:0] pos
);
  localparam logic [PW:0] CYC_X  = (PW+1)'(CYC);
  localparam logic [PW:0] HALF_X = (PW+1)'(CYC / 2);

  logic [PW:0]   raw_diff, fwd_diff, back_mag, lead_raw, lead_sum;
  logic [PW-1:0] pos_nxt;

  always_comb begin
    raw_diff = {1'b0, smp_angle} + CYC_X - {1'b0, pos};
    fwd_diff = (raw_diff >= CYC_X) ? raw_diff - CYC_X : raw_diff;
    back_mag = CYC_X - fwd_diff;
    lead_raw = {1'b0, smp_angle} + {1'b0, hyst};
    lead_sum = (lead_raw >= CYC_X) ? lead_raw - CYC_X : lead_raw;
    pos_nxt  = pos;
    if (fwd_diff != '0) begin
      if (fwd_diff < HALF_X)
        pos_nxt = smp_angle;            // moving ahead: follow at once
      else if (back_mag > {1'b0, hyst})
        pos_nxt = lead_sum[PW-1:0];     // moving back: trail by the dead band
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           pos <= '0;
    else if (smp_take) pos <= pos_nxt;
  end
endmodule

// File: rtl/quadgen_seg_step.sv
module quadgen_seg_step #(
  parameter int CYC = 960,
  parameter int PW  = 10,
  parameter int SW  = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] span,
  input  logic [SW-1:0] nseg,
  output logic [SW-1:0] seg
);
  localparam logic [PW:0] CYC_X  = (PW+1)'(CYC);
  localparam logic [PW:0] HALF_X = (PW+1)'(CYC / 2);

  logic [PW:0]   base, off_raw, off;
  logic [SW-1:0] seg_nxt, seg_last;

  always_comb begin
    base     = (PW+1)'(seg) * {1'b0, span};
    off_raw  = {1'b0, pos} + CYC_X - base;
    off      = (off_raw >= CYC_X) ? off_raw - CYC_X : off_raw;
    seg_last = nseg - SW'(1);
    seg_nxt  = seg;
    if (seg >= nseg)
      seg_nxt = '0;                                   // resync after a factor change
    else if (off >= {1'b0, span}) begin
      if (off < HALF_X)
        seg_nxt = (seg == seg_last) ? '0 : seg + SW'(1);
      else
        seg_nxt = (seg == '0) ? seg_last : seg - SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) seg <= '0;
    else     seg <= seg_nxt;
  end
endmodule

// File: rtl/quadgen_out_map.sv
module quadgen_out_map
  import quadgen_pkg::*;
(
  input  logic [1:0] seg_lsb,
  input  logic [1:0] phase_sel,
  input  logic       msb_q,
  output logic       quad_a,
  output logic       quad_b,
  output logic       sync_out
);
  tri_lvl_e lvl;
  logic     gray_lead, gray_lag;

  always_comb begin
    lvl       = lvl_norm(phase_sel);
    gray_lead = seg_lsb[0] ^ seg_lsb[1];
    gray_lag  = seg_lsb[1];
    if (lvl == LVL_HI) begin
      quad_a = gray_lead;
      quad_b = gray_lag;
    end else begin
      quad_a = gray_lag;
      quad_b = gray_lead;
    end
    sync_out = (lvl == LVL_OPEN) && msb_q;
  end
endmodule

// File: rtl/interp_quad_gen.sv
module interp_quad_gen #(
  parameter int CYCLE_COUNTS = 960,
  parameter int MAX_SEGS     = 64,
  localparam int AW = $clog2(CYCLE_COUNTS),
  localparam int SW = $clog2(MAX_SEGS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_angle,
  input  logic [1:0]    res_coarse,
  input  logic [1:0]    res_fine,
  input  logic [1:0]    phase_sel,
  output logic          quad_a,
  output logic          quad_b,
  output logic          sync_out
);
  localparam logic [AW-1:0] HALF = AW'(CYCLE_COUNTS / 2);

  logic [AW-1:0] cfg_span, cfg_hyst, trk_pos;
  logic [SW-1:0] cfg_nseg, seg_q;
  logic          take, msb_q;

  assign in_ready = ~rst;
  assign take     = in_valid & in_ready;

  quadgen_res_decode #(.CYC(CYCLE_COUNTS), .PW(AW), .SW(SW)) u_dec (
    .sel_coarse (res_coarse),
    .sel_fine   (res_fine),
    .span       (cfg_span),
    .hyst       (cfg_hyst),
    .nseg       (cfg_nseg)
  );

  quadgen_hyst_track #(.CYC(CYCLE_COUNTS), .PW(AW)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .smp_take  (take),
    .smp_angle (in_angle),
    .hyst      (cfg_hyst),
    .pos       (trk_pos)
  );

  quadgen_seg_step #(.CYC(CYCLE_COUNTS), .PW(AW), .SW(SW)) u_step (
    .clk  (clk),
    .rst  (rst),
    .pos  (trk_pos),
    .span (cfg_span),
    .nseg (cfg_nseg),
    .seg  (seg_q)
  );

  always_ff @(posedge clk) begin
    if (rst)       msb_q <= 1'b0;
    else if (take) msb_q <= (in_angle >= HALF);
  end

  quadgen_out_map u_map (
    .seg_lsb   (seg_q[1:0]),
    .phase_sel (phase_sel),
    .msb_q     (msb_q),
    .quad_a    (quad_a),
    .quad_b    (quad_b),
    .sync_out  (sync_out)
  );
endmodule

// File: rtl/interp_quad_gen_chk.sv
module interp_quad_gen_chk #(
  parameter int AW = 10,
  parameter int SW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    phase_sel,
  input logic          quad_a,
  input logic          quad_b,
  input logic [AW-1:0] pos,
  input logic [SW-1:0] seg,
  input logic [SW-1:0] nseg
);
  // R7: never both outputs in one clock while configuration is steady
  p_single_edge_r7: assert property (@(posedge clk) disable iff (rst)
    ($stable(phase_sel) && $stable(nseg) && ($past(seg) < nseg))
      |-> !((quad_a != $past(quad_a)) && (quad_b != $past(quad_b))));

  // R7: segment moves by exactly one, with wrap
  p_seg_unit_step_r7: assert property (@(posedge clk) disable iff (rst)
    ($stable(nseg) && ($past(seg) < nseg) && (seg != $past(seg)))
      |-> ((seg == (($past(seg) == nseg - SW'(1)) ? '0 : $past(seg) + SW'(1))) ||
           (seg == (($past(seg) == '0) ? nseg - SW'(1) : $past(seg) - SW'(1)))));

  // R1: segment stays inside the range of the selected factor
  p_seg_range_r1: assert property (@(posedge clk) disable iff (rst)
    $stable(nseg) |-> (seg < nseg));

  // R6: follower holds without an accepted sample
  p_pos_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid && in_ready) |-> $stable(pos));

  // R9: outputs low right after reset
  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!quad_a && !quad_b));
endmodule

bind interp_quad_gen interp_quad_gen_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .phase_sel (phase_sel),
  .quad_a    (quad_a),
  .quad_b    (quad_b),
  .pos       (trk_pos),
  .seg       (seg_q),
  .nseg      (cfg_nseg)
);

// File: tb/test_interp_quad_gen.sv
module test_interp_quad_gen;
  localparam int SETTLE = 80;
  localparam logic [1:0] LO = 2'b00, OP = 2'b01, HI = 2'b10, OP2 = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_angle = '0;
  logic [1:0] res_coarse = HI, res_fine = HI, phase_sel = LO;
  logic       quad_a, quad_b, sync_out;

  int n_checks = 0, n_fail = 0;
  int edges = 0, dbl = 0;
  bit mon_on = 0, done = 0;
  logic pa = 0, pb = 0;

  always #5 clk = ~clk;

  interp_quad_gen i_interp_quad_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_angle(in_angle), .res_coarse(res_coarse), .res_fine(res_fine),
    .phase_sel(phase_sel), .quad_a(quad_a), .quad_b(quad_b), .sync_out(sync_out)
  );

  always @(negedge clk) begin
    if (mon_on) begin
      if (quad_a != pa) edges++;
      if (quad_b != pb) edges++;
      if (quad_a != pa && quad_b != pb) dbl++;
    end
    pa = quad_a;
    pb = quad_b;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_ab(input logic ea, input logic eb, input string req);
    check(quad_a == ea && quad_b == eb, req, {quad_a, quad_b}, {ea, eb});
  endtask

  task automatic do_reset(input logic [1:0] c, input logic [1:0] f, input logic [1:0] ph);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    res_coarse = c; res_fine = f; phase_sel = ph;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input int ang);
    @(negedge clk);
    in_angle = 10'(ang); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic t_reset_r9_r10();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(in_ready == 1'b0, "R10 ready low in reset", in_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R10 ready high after reset", in_ready, 1);
    check_ab(1'b0, 1'b0, "R9 outputs after reset");
    check(sync_out == 1'b0, "R9 sync after reset", sync_out, 0);
  endtask

  task automatic t_forward_r2_r3();
    do_reset(HI, HI, LO);
    send(14); check_ab(0, 0, "R2 angle 14 seg0");
    send(15); check_ab(0, 1, "R3 B leads at 15");
    send(29); check_ab(0, 1, "R2 angle 29 seg1");
    send(30); check_ab(1, 1, "R3 A follows at 30");
    send(45); check_ab(1, 0, "R3 seg3 at 45");
    send(60); check_ab(0, 0, "R3 seg4 at 60");
  endtask

  task automatic t_reverse_r5();
    do_reset(HI, HI, LO);
    send(15); send(30); send(45); send(60);
    send(59); check_ab(0, 0, "R5 reversal 1 count held");
    send(45); check_ab(0, 0, "R5 reversal 15 counts held");
    send(44); check_ab(1, 0, "R5 reversal past band");
    send(29); check_ab(1, 1, "R5 trailing by band");
    send(30); check_ab(1, 1, "R5 forward reversal held");
    send(45); check_ab(1, 0, "R5 forward again");
    do_reset(HI, LO, LO);                     // factor 10, band 24
    send(24); send(48); check_ab(1, 1, "R5 f10 forward");
    send(24); check_ab(1, 1, "R5 f10 band 24 held");
    send(23); check_ab(0, 1, "R5 f10 past band");
    do_reset(HI, OP, LO);                     // factor 12, band 20
    send(20); send(40); check_ab(1, 1, "R5 f12 forward");
    send(20); check_ab(1, 1, "R5 f12 band 20 held");
    send(19); check_ab(0, 1, "R5 f12 past band");
    do_reset(LO, LO, LO);                     // factor 1, band 15
    send(120); send(240); check_ab(0, 1, "R5 f1 forward");
    send(225); check_ab(0, 1, "R5 f1 band 15 held");
    send(224); check_ab(0, 0, "R5 f1 past band");
    do_reset(OP2, OP2, LO);                   // 11 read as open: factor 5, band 24
    send(30); check_ab(0, 0, "R1 f5 via 11 below 48");
    send(48); check_ab(0, 1, "R1 f5 via 11 at 48");
    send(24); check_ab(0, 1, "R5 f5 band 24 held");
    send(23); check_ab(0, 0, "R5 f5 past band");
  endtask

  task automatic t_decode_r1();
    for (int i = 0; i < 9; i++) begin
      logic [1:0] c, f;
      int ipf, sp;
      c = (i < 3) ? HI : (i < 6) ? OP : LO;
      f = (i % 3 == 0) ? HI : (i % 3 == 1) ? OP : LO;
      case (i)
        0: ipf = 16; 1: ipf = 12; 2: ipf = 10; 3: ipf = 8; 4: ipf = 5;
        5: ipf = 4;  6: ipf = 3;  7: ipf = 2;  default: ipf = 1;
      endcase
      sp = 960 / (4 * ipf);
      do_reset(c, f, LO);
      send(sp - 1); check_ab(0, 0, $sformatf("R1 factor %0d below first edge", ipf));
      send(sp);     check_ab(0, 1, $sformatf("R1 factor %0d first edge", ipf));
      send(2 * sp); check_ab(1, 1, $sformatf("R2 factor %0d second edge", ipf));
    end
  endtask

  task automatic t_rot_hi_r4();
    do_reset(HI, HI, HI);
    send(15); check_ab(1, 0, "R4 A leads at 15");
    send(30); check_ab(1, 1, "R4 seg2");
    send(45); check_ab(0, 1, "R4 seg3");
    send(60); check_ab(0, 0, "R4 seg4");
  endtask

  task automatic t_jump_r7();
    do_reset(HI, HI, LO);
    edges = 0; dbl = 0; mon_on = 1;
    send(150);
    mon_on = 0;
    check(edges == 10, "R7 forward jump edge count", edges, 10);
    check(dbl == 0, "R7 no simultaneous edges", dbl, 0);
    check_ab(1, 1, "R7 forward jump end seg10");
    do_reset(HI, HI, LO);
    edges = 0; dbl = 0; mon_on = 1;
    send(900);                                // backward via wrap: seg 61
    mon_on = 0;
    check(edges == 3, "R7 wrap jump edge count", edges, 3);
    check(dbl == 0, "R7 wrap no simultaneous edges", dbl, 0);
    check_ab(0, 1, "R7 wrap jump end seg61");
  endtask

  task automatic t_static_r6();
    do_reset(HI, HI, LO);
    send(15); send(30);
    edges = 0; mon_on = 1;
    @(negedge clk);
    in_angle = 10'd200; in_valid = 1'b0;
    repeat (40) @(negedge clk);
    check(edges == 0, "R6 bus ignored without valid", edges, 0);
    check_ab(1, 1, "R6 state kept without valid");
    in_angle = 10'd30; in_valid = 1'b1;
    repeat (40) @(negedge clk);
    in_valid = 1'b0;
    mon_on = 0;
    check(edges == 0, "R6 static input no edges", edges, 0);
    check_ab(1, 1, "R6 state kept on static input");
  endtask

  task automatic t_sync_r8();
    do_reset(HI, HI, OP);
    send(500); check(sync_out == 1, "R8 sync at 500", sync_out, 1);
    send(479); check(sync_out == 0, "R8 sync at 479", sync_out, 0);
    send(480); check(sync_out == 1, "R8 sync at 480", sync_out, 1);
    @(negedge clk); phase_sel = OP2; @(negedge clk);
    check(sync_out == 1, "R8 sync with 11 as open", sync_out, 1);
    phase_sel = LO; @(negedge clk);
    check(sync_out == 0, "R8 sync low with phase low", sync_out, 0);
    phase_sel = HI; @(negedge clk);
    check(sync_out == 0, "R8 sync low with phase high", sync_out, 0);
    phase_sel = OP; @(negedge clk);
    send(100); check(sync_out == 0, "R8 sync at 100", sync_out, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R1 run did not finish actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r9_r10();
    t_forward_r2_r3();
    t_reverse_r5();
    t_decode_r1();
    t_rot_hi_r4();
    t_jump_r7();
    t_static_r6();
    t_sync_r8();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule